// File: doc/BRIEF.md
# Dual-Wiper Register Bank Controller

This block keeps the digital state behind a pair of 8-bit wiper codes. Two volatile wiper registers drive the outputs `wiper0_o` and `wiper1_o`. Beside them sits an eight-byte store that stands for non-volatile memory. In that store, bytes 0 and 1 hold the power-up codes of the two wipers, bytes 2 to 6 are free storage for the user, and byte 7 is reserved. A host reaches all of this through a plain byte port: an address, write data, and one-cycle write and read strobes. A registered read data output returns the result.

A volatile mode byte sits at address 8. It decides where accesses to addresses 0 and 1 go:
- In the non-volatile mode, value 00h, those accesses reach the stored initial values.
- In the volatile mode, value 80h, they reach only the wiper registers.

The same mode byte also controls access to the general-purpose bytes.

At power-up the wipers are held at mid-scale (80h) and `ready_o` stays low. Once the supply-ready input is seen high, the wipers are loaded from the stored bytes and the port opens. If the supply input drops, the block goes back to mid-scale and repeats the load when the supply returns. The active-low reset stands for a full power-on. It also returns the store to its default contents: 80h in bytes 0 and 1 and 00h everywhere else.

Top module: `wiper_bank_ctrl`

## Requirements
- R1: After reset, `ready_o` is 0, both wipers are 80h and `rdata_o` is 00h. The mode byte at address 8 is 00h, store bytes 0 and 1 hold 80h, and store bytes 2 to 7 hold 00h.
- R2: While `ready_o` is low, both wipers read 80h. When `supply_ok_i` is low at a clock edge while the block is ready, `ready_o` falls and the wipers return to 80h at that same edge.
- R3: After the first edge that samples `supply_ok_i` high while the block waits, `ready_o` rises at the next edge. At that same edge, wiper 0 and wiper 1 take the values of store bytes 0 and 1.
- R4: While `ready_o` is low, port reads and writes have no effect on any register, the store, or `rdata_o`.
- R5: With mode 00h, a read of address 0 or 1 returns store byte 0 or 1. A write to address 0 or 1 puts the same value into the matching wiper and the matching store byte.
- R6: With mode 80h, a read of address 0 or 1 returns wiper 0 or 1. A write to address 0 or 1 changes only that wiper and leaves the store byte as it was.
- R7: Store bytes 2 to 6 can be read and written only in mode 00h. In mode 80h, writes to them are dropped and reads return 00h.
- R8: A write to address 8 takes effect only with the value 00h or 80h. Any other value leaves the mode byte unchanged. A read of address 8 returns the mode byte.
- R9: A write to address 7, or to any address from 9 to 15, changes nothing. A read of any of those addresses returns 00h.
- R10: `rdata_o` changes only at an edge that samples `rd_i` high while ready, and then holds until the next such read. When a read and a write arrive in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-on) |
| supply_ok_i | input | 1 | Supply judged good for a reliable store read |
| addr_i | input | 4 | Byte address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| wiper0_o | output | 8 | Wiper 0 code |
| wiper1_o | output | 8 | Wiper 1 code |
| ready_o | output | 1 | Load done, port open |

## Verification
A write or read strobed before a clock edge shows its effect on the wiper outputs and on `rdata_o` right after that edge. The bench therefore drives each operation on a falling edge, lets one rising edge pass, and compares every output against its model on the next falling edge. For the power-up sequence, the bench checks after the first rising edge that `ready_o` is still low with the wipers at mid-scale, and after the second rising edge that `ready_o` is high with the wipers loaded. A supply drop is checked one edge after it is applied.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    PS_WAIT = 2'd0,
    PS_LOAD = 2'd1,
    PS_RUN  = 2'd2
  } pwr_state_e;

  typedef enum logic [1:0] {
    RSEL_ZERO  = 2'd0,
    RSEL_NV    = 2'd1,
    RSEL_WIPER = 2'd2,
    RSEL_CTRL  = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/wbc_nv_store.sv
module wbc_nv_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned NUM_IV = 2,
  parameter int unsigned AW = $clog2(DEPTH),
  parameter logic [DATA_W-1:0] IV_DEFAULT = 8'h80
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [AW-1:0]                 waddr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DEPTH-1:0][DATA_W-1:0]  mem_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    localparam logic [DATA_W-1:0] RST_VAL = (g < NUM_IV) ? IV_DEFAULT : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[g] <= RST_VAL;
      else if (we_i && (waddr_i == AW'(g)))     mem_q[g] <= wdata_i;
    end
    assign mem_o[g] = mem_q[g];
  end
endmodule

// File: rtl/wbc_pwrup_seq.sv
module wbc_pwrup_seq
  import wbc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  output logic preset_o,
  output logic load_o,
  output logic ready_o
);
  pwr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_WAIT: if (supply_ok_i) state_d = PS_LOAD;
      PS_LOAD: state_d = PS_RUN;
      PS_RUN:  if (!supply_ok_i) state_d = PS_WAIT;
      default: state_d = PS_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PS_WAIT;
    else         state_q <= state_d;
  end

  // preset on entry to and during wait, so wipers never lag ready_o
  assign preset_o = (state_d == PS_WAIT);
  assign load_o   = (state_q == PS_LOAD);
  assign ready_o  = (state_q == PS_RUN);
endmodule

// File: rtl/wbc_access_dec.sv
module wbc_access_dec
  import wbc_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NV_DEPTH = 8,
  parameter int unsigned NUM_WIPERS = 2,
  parameter logic [DATA_W-1:0] CTRL_NV = 8'h00,
  parameter logic [DATA_W-1:0] CTRL_VOL = 8'h80
) (
  input  logic                  ready_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [DATA_W-1:0]     ctrl_i,
  output logic                  nv_we_o,
  output logic [NUM_WIPERS-1:0] wiper_we_o,
  output logic                  ctrl_we_o,
  output logic                  rd_en_o,
  output rd_sel_e               rd_sel_o
);
  localparam logic [ADDR_W-1:0] WIP_END   = ADDR_W'(NUM_WIPERS);
  localparam logic [ADDR_W-1:0] RSVD_ADDR = ADDR_W'(NV_DEPTH - 1);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NV_DEPTH);

  logic wr_ok, is_wip, is_gp, is_ctrl, nv_mode, vol_mode;

  assign wr_ok    = ready_i && wr_i;
  assign rd_en_o  = ready_i && rd_i;
  assign is_wip   = addr_i < WIP_END;
  assign is_gp    = (addr_i >= WIP_END) && (addr_i < RSVD_ADDR);
  assign is_ctrl  = addr_i == CTRL_ADDR;
  assign nv_mode  = ctrl_i == CTRL_NV;
  assign vol_mode = ctrl_i == CTRL_VOL;

  assign nv_we_o   = wr_ok && nv_mode && (is_wip || is_gp);
  assign ctrl_we_o = wr_ok && is_ctrl && ((wdata_i == CTRL_NV) || (wdata_i == CTRL_VOL));

  for (genvar g = 0; g < NUM_WIPERS; g++) begin : g_wwe
    assign wiper_we_o[g] = wr_ok && (addr_i == ADDR_W'(g)) && (nv_mode || vol_mode);
  end

  always_comb begin
    rd_sel_o = RSEL_ZERO;
    if (is_wip && nv_mode)       rd_sel_o = RSEL_NV;
    else if (is_wip && vol_mode) rd_sel_o = RSEL_WIPER;
    else if (is_gp && nv_mode)   rd_sel_o = RSEL_NV;
    else if (is_ctrl)            rd_sel_o = RSEL_CTRL;
  end
endmodule

// File: rtl/wiper_bank_ctrl.sv
module wiper_bank_ctrl
  import wbc_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NV_DEPTH = 8,
  parameter logic [DATA_W-1:0] PRESET = 8'h80,
  parameter logic [DATA_W-1:0] CTRL_VOL = 8'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              supply_ok_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] wiper0_o,
  output logic [DATA_W-1:0] wiper1_o,
  output logic              ready_o
);
  localparam int unsigned NUM_WIPERS = 2;
  localparam int unsigned NV_AW = $clog2(NV_DEPTH);
  localparam int unsigned WIX_W = $clog2(NUM_WIPERS);
  localparam logic [DATA_W-1:0] CTRL_NV = '0;

  logic preset, load, ready;
  logic nv_we, ctrl_we, rd_en;
  logic [NUM_WIPERS-1:0] wiper_we;
  rd_sel_e rd_sel;
  logic [NV_DEPTH-1:0][DATA_W-1:0] nv_mem;
  logic [NUM_WIPERS-1:0][DATA_W-1:0] wiper_q;
  logic [DATA_W-1:0] ctrl_q, rdata_q, rdata_d;

  wbc_pwrup_seq i_seq (
    .clk_i, .rst_ni, .supply_ok_i,
    .preset_o(preset), .load_o(load), .ready_o(ready)
  );

  wbc_access_dec #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NV_DEPTH(NV_DEPTH),
    .NUM_WIPERS(NUM_WIPERS), .CTRL_NV(CTRL_NV), .CTRL_VOL(CTRL_VOL)
  ) i_dec (
    .ready_i(ready), .wr_i, .rd_i, .addr_i, .wdata_i, .ctrl_i(ctrl_q),
    .nv_we_o(nv_we), .wiper_we_o(wiper_we), .ctrl_we_o(ctrl_we),
    .rd_en_o(rd_en), .rd_sel_o(rd_sel)
  );

  wbc_nv_store #(
    .DATA_W(DATA_W), .DEPTH(NV_DEPTH), .NUM_IV(NUM_WIPERS),
    .AW(NV_AW), .IV_DEFAULT(PRESET)
  ) i_nv (
    .clk_i, .rst_ni, .we_i(nv_we), .waddr_i(addr_i[NV_AW-1:0]),
    .wdata_i, .mem_o(nv_mem)
  );

  for (genvar g = 0; g < NUM_WIPERS; g++) begin : g_wiper
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          wiper_q[g] <= PRESET;
      else if (preset)      wiper_q[g] <= PRESET;
      else if (load)        wiper_q[g] <= nv_mem[g];
      else if (wiper_we[g]) wiper_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= CTRL_NV;
    else if (ctrl_we) ctrl_q <= wdata_i;
  end

  always_comb begin
    unique case (rd_sel)
      RSEL_NV:    rdata_d = nv_mem[addr_i[NV_AW-1:0]];
      RSEL_WIPER: rdata_d = wiper_q[addr_i[WIX_W-1:0]];
      RSEL_CTRL:  rdata_d = ctrl_q;
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign rdata_o  = rdata_q;
  assign wiper0_o = wiper_q[0];
  assign wiper1_o = wiper_q[1];
  assign ready_o  = ready;
endmodule

// File: rtl/wbc_chk.sv
module wbc_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4,
  parameter logic [DATA_W-1:0] PRESET = 8'h80,
  parameter logic [DATA_W-1:0] CTRL_VOL = 8'h80
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              supply_ok_i,
  input logic              ready_o,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] wiper0_o,
  input logic [DATA_W-1:0] wiper1_o,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] iv0,
  input logic [DATA_W-1:0] iv1
);
  // R2
  wiper_preset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (wiper0_o == PRESET && wiper1_o == PRESET));

  // R2
  supply_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !supply_ok_i |=> !ready_o);

  // R3
  ready_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(supply_ok_i, 2));

  // R3
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && supply_ok_i |=> ready_o);

  // R4
  store_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> ($stable(iv0) && $stable(iv1)));

  // R8
  ctrl_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q == '0) || (ctrl_q == CTRL_VOL));

  // R5 R6
  wiper_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && supply_ok_i && wr_i && (addr_i == '0) && ((ctrl_q == '0) || (ctrl_q == CTRL_VOL))
    |=> wiper0_o == $past(wdata_i));

  // R5 R6
  iv_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !$stable(iv1) |-> wiper1_o == iv1);
endmodule

bind wiper_bank_ctrl wbc_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRESET(PRESET), .CTRL_VOL(CTRL_VOL)
) i_wbc_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .supply_ok_i(supply_ok_i), .ready_o(ready_o),
  .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .wiper0_o(wiper0_o), .wiper1_o(wiper1_o), .ctrl_q(ctrl_q),
  .iv0(nv_mem[0]), .iv1(nv_mem[1])
);

// File: tb/test_wiper_bank_ctrl.sv
module test_wiper_bank_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       supply_ok_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] rdata_o, wiper0_o, wiper1_o;
  logic       ready_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  logic [7:0] nv_m [8];
  logic [7:0] wip_m [2];
  logic [7:0] ctrl_m, rd_m;
  bit         rdy_m;

  always #2 clk_i = ~clk_i;

  wiper_bank_ctrl i_wiper_bank_ctrl (
    .clk_i, .rst_ni, .supply_ok_i, .addr_i, .wdata_i, .wr_i, .rd_i,
    .rdata_o, .wiper0_o, .wiper1_o, .ready_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    if (a <= 4'd1) begin
      if (ctrl_m == 8'h00) return nv_m[a[2:0]];
      if (ctrl_m == 8'h80) return wip_m[a[0]];
      return 8'h00;
    end
    if (a >= 4'd2 && a <= 4'd6) return (ctrl_m == 8'h00) ? nv_m[a[2:0]] : 8'h00;
    if (a == 4'd8) return ctrl_m;
    return 8'h00;
  endfunction

  task automatic model_op(input bit w, input bit r, input logic [3:0] a, input logic [7:0] d);
    if (!rdy_m) return;
    if (r) rd_m = exp_read(a);
    if (w) begin
      if (a <= 4'd1) begin
        if (ctrl_m == 8'h00) begin nv_m[a[2:0]] = d; wip_m[a[0]] = d; end
        else if (ctrl_m == 8'h80) wip_m[a[0]] = d;
      end else if (a >= 4'd2 && a <= 4'd6) begin
        if (ctrl_m == 8'h00) nv_m[a[2:0]] = d;
      end else if (a == 4'd8) begin
        if (d == 8'h00 || d == 8'h80) ctrl_m = d;
      end
    end
  endtask

  task automatic check_outs(input string req);
    check(rdata_o == rd_m, {req, " rdata"}, rdata_o, rd_m);
    check(wiper0_o == wip_m[0], {req, " wiper0"}, wiper0_o, wip_m[0]);
    check(wiper1_o == wip_m[1], {req, " wiper1"}, wiper1_o, wip_m[1]);
    check(ready_o == rdy_m, {req, " ready"}, ready_o, rdy_m);
  endtask

  task automatic op(input bit w, input bit r, input logic [3:0] a, input logic [7:0] d, input string req);
    @(negedge clk_i);
    wr_i = w; rd_i = r; addr_i = a; wdata_i = d;
    model_op(w, r, a, d);
    @(posedge clk_i);
    @(negedge clk_i);
    wr_i = 1'b0; rd_i = 1'b0;
    check_outs(req);
  endtask

  task automatic power_up();
    @(negedge clk_i);
    supply_ok_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    check(!ready_o, "R3 ready after one edge", ready_o, 0);
    check(wiper0_o == 8'h80, "R2 wiper0 before load", wiper0_o, 8'h80);
    @(posedge clk_i);
    @(negedge clk_i);
    rdy_m = 1'b1;
    wip_m[0] = nv_m[0];
    wip_m[1] = nv_m[1];
    check_outs("R3 load");
  endtask

  task automatic power_down();
    @(negedge clk_i);
    supply_ok_i = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    rdy_m = 1'b0;
    wip_m[0] = 8'h80;
    wip_m[1] = 8'h80;
    check_outs("R2 supply drop");
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 8; i++) nv_m[i] = (i < 2) ? 8'h80 : 8'h00;
    wip_m[0] = 8'h80; wip_m[1] = 8'h80;
    ctrl_m = 8'h00; rd_m = 8'h00; rdy_m = 1'b0;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check_outs("R1 reset");

    // R4: accesses before ready
    op(1'b1, 1'b1, 4'd0, 8'h55, "R4 wr before ready");
    op(1'b1, 1'b0, 4'd8, 8'h80, "R4 ctrl before ready");
    op(1'b0, 1'b1, 4'd3, 8'h00, "R4 rd before ready");

    power_up();
    // R1 defaults
    op(1'b0, 1'b1, 4'd8, 8'h00, "R1 ctrl default");
    op(1'b0, 1'b1, 4'd0, 8'h00, "R1 byte0 default");
    op(1'b0, 1'b1, 4'd1, 8'h00, "R1 byte1 default");
    op(1'b0, 1'b1, 4'd4, 8'h00, "R1 gp default");
    // R5
    op(1'b1, 1'b0, 4'd0, 8'h11, "R5 write both");
    op(1'b0, 1'b1, 4'd0, 8'h00, "R5 read store");
    // R6
    op(1'b1, 1'b0, 4'd8, 8'h80, "R8 set volatile");
    op(1'b1, 1'b0, 4'd1, 8'h22, "R6 wiper only");
    op(1'b0, 1'b1, 4'd1, 8'h00, "R6 read wiper");
    op(1'b1, 1'b0, 4'd8, 8'h00, "R8 set nv");
    op(1'b0, 1'b1, 4'd1, 8'h00, "R6 store untouched");
    // R7
    op(1'b1, 1'b0, 4'd3, 8'h33, "R7 gp write");
    op(1'b0, 1'b1, 4'd3, 8'h00, "R7 gp read");
    op(1'b1, 1'b0, 4'd8, 8'h80, "R8 set volatile");
    op(1'b1, 1'b0, 4'd3, 8'h44, "R7 gp write blocked");
    op(1'b0, 1'b1, 4'd3, 8'h00, "R7 gp read zero");
    // R8
    op(1'b1, 1'b0, 4'd8, 8'h40, "R8 illegal ctrl");
    op(1'b0, 1'b1, 4'd8, 8'h00, "R8 ctrl kept");
    op(1'b1, 1'b0, 4'd8, 8'h00, "R8 set nv");
    op(1'b0, 1'b1, 4'd3, 8'h00, "R7 gp kept");
    // R9
    op(1'b1, 1'b0, 4'd7, 8'h77, "R9 rsvd write");
    op(1'b0, 1'b1, 4'd7, 8'h00, "R9 rsvd read");
    op(1'b1, 1'b1, 4'd12, 8'h99, "R9 high addr");
    // R10
    op(1'b1, 1'b1, 4'd0, 8'h5a, "R10 read old");
    op(1'b0, 1'b0, 4'd0, 8'h00, "R10 hold");
    op(1'b0, 1'b1, 4'd0, 8'h00, "R10 read new");

    power_down();
    op(1'b1, 1'b0, 4'd0, 8'hee, "R4 wr while down");
    power_up();
    op(1'b0, 1'b1, 4'd0, 8'h00, "R3 reloaded");

    for (int i = 0; i < 500; i++) begin
      logic [3:0] a;
      logic [7:0] d;
      bit w, r;
      a = 4'($urandom % 16);
      d = 8'($urandom);
      if ($urandom % 5 == 0) begin
        a = 4'd8;
        case ($urandom % 3)
          0: d = 8'h00;
          1: d = 8'h80;
          default: d = 8'($urandom);
        endcase
      end
      w = ($urandom % 2) == 1;
      r = ($urandom % 2) == 1;
      op(w, r, a, d, "R5 R6 R7 R10 random");
    end

    power_down();
    power_up();
    op(1'b0, 1'b1, 4'd1, 8'h00, "R3 final reload");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule